// File: doc/BRIEF.md
# Page-Mode Program Fetch Sequencer

This block sits between a single-cycle processor core and an external program memory that shares one multiplexed address port. It remembers the upper address byte (the page) it last put on the bus. A fetch into that page needs one clock, and only the lower byte is driven. A fetch to any other page needs two clocks. In the first clock the upper byte goes out with a latch strobe, so that an external register can hold it. In the second clock the lower byte goes out. Instruction bytes come back on a separate data port. The active-low read enable stays low for as long as the fast page mode is active. It does not toggle between fetches.

The core raises a fetch request with an address and holds them until the block acknowledges. In the acknowledge cycle the core also supplies a stall count, equal to the instruction's cycle count minus one. For that many following clocks the block accepts no fetch, and the address on the bus does not move. The fast mode is armed by a two-step configuration. The 2-bit timing field must read zero at the moment the enable bit rises.

Top module: `pgmode_fetch`

## Requirements
- R1: After reset, bus_rd_n is 1, bus_ale is 0, fetch_ack is 0 and byte_valid is 0.
- R2: The fast mode turns on only when cfg_en rises while cfg_timing equals 2'b00. bus_rd_n goes low one clock after that rising edge. If cfg_en rises while cfg_timing is non-zero, the mode stays off, even after cfg_timing later returns to 00 with cfg_en still high.
- R3: While the mode is off, bus_rd_n is 1, and bus_ale and fetch_ack stay 0 whatever the request inputs do.
- R4: The first fetch after reset, and the first fetch after the mode is re-entered, is treated as a page miss, even when its upper byte equals the last page used.
- R5: A page miss takes two clocks. In the first clock bus_addr carries address bits [15:8] with bus_ale=1 and fetch_ack=0. In the second clock bus_addr carries bits [7:0] with bus_ale=0 and fetch_ack=1.
- R6: A page hit, where the upper byte equals the page stored by the last acknowledged fetch, takes one clock. bus_addr carries bits [7:0], bus_ale=0, and fetch_ack=1 in the same clock as the request.
- R7: While the mode stays on, bus_rd_n remains 0 in every clock: across hits, misses, stalls and idle clocks.
- R8: The byte on bus_data in the acknowledge clock appears on byte_out, with byte_valid=1, exactly one clock later. byte_valid is 0 in every clock that does not follow an acknowledge.
- R9: A stall count N (width SW) sampled at an acknowledge blocks the next N clocks. In those clocks fetch_ack and bus_ale stay 0 even with a request pending. Fetching resumes in the clock after them. N=8 models a 9-cycle instruction and N=1 a 2-cycle one.
- R10: A fetch whose upper byte differs from the stored page is a miss, and its acknowledge replaces the stored page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Page-mode enable bit |
| cfg_timing | input | 2 | Page timing field, 00 selects single-cycle |
| fetch_req | input | 1 | Core fetch request, held until acknowledged |
| fetch_addr | input | AW | Fetch address |
| stall_cnt | input | SW | Extra stall clocks, sampled at acknowledge |
| fetch_ack | output | 1 | Fetch completes this clock |
| byte_valid | output | 1 | byte_out holds a fresh instruction byte |
| byte_out | output | PW | Instruction byte to the core |
| bus_addr | output | PW | Multiplexed external address port |
| bus_ale | output | 1 | Upper-byte latch strobe, high in miss first clock |
| bus_rd_n | output | 1 | Active-low program read enable |
| bus_data | input | PW | Instruction byte from external memory |

## Verification
If the stored page or its valid flag goes wrong, the very next fetch takes the wrong number of clocks. A miss taken as a hit returns a byte read through the wrong external upper latch, and byte_out differs one clock later. A hit taken as a miss shows a spurious bus_ale. A wrong stall counter shows as an acknowledge inside a stall window, or as a missing acknowledge right after it, within N+1 clocks. A wrong mode flag shows immediately on bus_rd_n.

// File: rtl/pgf_pkg.sv
package pgf_pkg;
   typedef enum logic [1:0] {
      SQ_RUN   = 2'd0,
      SQ_MISS2 = 2'd1,
      SQ_STALL = 2'd2
   } seq_st_t;
endpackage

// File: rtl/pgf_mode_gate.sv
// Arms single-cycle page mode only on an enable rising edge seen with the
// timing field at zero; drops it when enable falls or the field changes.
module pgf_mode_gate #(
   parameter int TW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic [TW-1:0] cfg_timing,
   output logic          mode_on
);
   logic en_q;
   logic tm_zero;

   assign tm_zero = (cfg_timing == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         mode_on <= 1'b0;
      end else begin
         en_q    <= cfg_en;
         mode_on <= cfg_en && tm_zero && (mode_on || !en_q);
      end
   end
endmodule

// File: rtl/pgf_page_track.sv
// Holds the last page put on the bus and a valid flag; flag clears whenever
// the mode is off so the first fetch after entry misses.
module pgf_page_track #(
   parameter int HW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_on,
   input  logic          upd,
   input  logic [HW-1:0] hi_in,
   output logic          hit
);
   logic [HW-1:0] pg_q;
   logic          pg_vld;

   assign hit = pg_vld && (pg_q == hi_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pg_q   <= '0;
         pg_vld <= 1'b0;
      end else if (!mode_on) begin
         pg_vld <= 1'b0;
      end else if (upd) begin
         pg_q   <= hi_in;
         pg_vld <= 1'b1;
      end
   end
endmodule

// File: rtl/pgf_seq.sv
// Bus cycle sequencer: one-clock hit, two-clock miss, stall window after ack.
module pgf_seq
   import pgf_pkg::*;
#(
   parameter int PW = 8,
   parameter int HW = 8,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_on,
   input  logic          req,
   input  logic [PW-1:0] lo,
   input  logic [HW-1:0] hi,
   input  logic          hit,
   input  logic [SW-1:0] stall_in,
   output logic          ack,
   output logic          ale,
   output logic [PW-1:0] bus_addr
);
   seq_st_t       st, st_nx;
   logic [SW-1:0] cnt;
   logic [PW-1:0] lo_hold;
   logic [PW-1:0] hi_p;
   seq_st_t       after_ack;

   generate
      if (HW == PW) begin : g_full
         assign hi_p = hi;
      end else begin : g_pad
         assign hi_p = {{(PW-HW){1'b0}}, hi};
      end
   endgenerate

   assign after_ack = (stall_in != '0) ? SQ_STALL : SQ_RUN;

   always_comb begin
      ack      = 1'b0;
      ale      = 1'b0;
      bus_addr = lo_hold;
      st_nx    = st;
      if (!mode_on) begin
         st_nx = SQ_RUN;
      end else begin
         case (st)
            SQ_RUN: begin
               if (req) begin
                  if (hit) begin
                     ack      = 1'b1;
                     bus_addr = lo;
                     st_nx    = after_ack;
                  end else begin
                     ale      = 1'b1;
                     bus_addr = hi_p;
                     st_nx    = SQ_MISS2;
                  end
               end
            end
            SQ_MISS2: begin
               if (req) begin
                  ack      = 1'b1;
                  bus_addr = lo;
                  st_nx    = after_ack;
               end else begin
                  st_nx = SQ_RUN;
               end
            end
            SQ_STALL: begin
               if (cnt <= SW'(1)) st_nx = SQ_RUN;
            end
            default: st_nx = SQ_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SQ_RUN;
         cnt     <= '0;
         lo_hold <= '0;
      end else begin
         st <= st_nx;
         if (!mode_on)       cnt <= '0;
         else if (ack)       cnt <= stall_in;
         else if (cnt != '0) cnt <= cnt - SW'(1);
         if (ack) lo_hold <= lo;
      end
   end
endmodule

// File: rtl/pgmode_fetch.sv
module pgmode_fetch #(
   parameter int AW = 16,
   parameter int PW = 8,
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_en,
   input  logic [1:0]    cfg_timing,
   input  logic          fetch_req,
   input  logic [AW-1:0] fetch_addr,
   input  logic [SW-1:0] stall_cnt,
   output logic          fetch_ack,
   output logic          byte_valid,
   output logic [PW-1:0] byte_out,
   output logic [PW-1:0] bus_addr,
   output logic          bus_ale,
   output logic          bus_rd_n,
   input  logic [PW-1:0] bus_data
);
   localparam int HW = AW - PW;

   generate
      if (HW < 1 || HW > PW) begin : g_bad_aw
         $error("pgmode_fetch: AW-PW must lie in 1..PW");
      end
      if (SW < 1) begin : g_bad_sw
         $error("pgmode_fetch: SW must be at least 1");
      end
   endgenerate

   logic mode_on;
   logic hit;

   pgf_mode_gate #(.TW(2)) u_mode (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_timing(cfg_timing),
      .mode_on(mode_on)
   );

   pgf_page_track #(.HW(HW)) u_page (
      .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .upd(fetch_ack),
      .hi_in(fetch_addr[AW-1:PW]), .hit(hit)
   );

   pgf_seq #(.PW(PW), .HW(HW), .SW(SW)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .req(fetch_req),
      .lo(fetch_addr[PW-1:0]), .hi(fetch_addr[AW-1:PW]), .hit(hit),
      .stall_in(stall_cnt), .ack(fetch_ack), .ale(bus_ale),
      .bus_addr(bus_addr)
   );

   assign bus_rd_n = ~mode_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_valid <= 1'b0;
         byte_out   <= '0;
      end else begin
         byte_valid <= fetch_ack;
         if (fetch_ack) byte_out <= bus_data;
      end
   end
endmodule

// File: rtl/pgmode_fetch_chk.sv
module pgmode_fetch_chk #(
   parameter int SW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_en,
   input logic [1:0]    cfg_timing,
   input logic          fetch_req,
   input logic [SW-1:0] stall_cnt,
   input logic          fetch_ack,
   input logic          byte_valid,
   input logic          bus_ale,
   input logic          bus_rd_n
);
   logic [SW-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              rem <= '0;
      else if (bus_rd_n)       rem <= '0;
      else if (fetch_ack)      rem <= stall_cnt;
      else if (rem != '0)      rem <= rem - SW'(1);
   end

   a_r3_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_n |-> (!bus_ale && !fetch_ack));

   a_r5_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> !bus_ale);

   a_r5_miss_completes: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale |=> (fetch_ack || bus_rd_n || !fetch_req));

   a_r6_ack_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ack |-> !bus_ale);

   a_r7_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd_n && cfg_en && cfg_timing == 2'b00) |=> !bus_rd_n);

   a_r8_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_ack |=> byte_valid);

   a_r8_no_stray_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_ack |=> !byte_valid);

   a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (rem != '0 && !bus_rd_n) |-> (!fetch_ack && !bus_ale));
endmodule

bind pgmode_fetch pgmode_fetch_chk #(.SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_timing(cfg_timing),
   .fetch_req(fetch_req), .stall_cnt(stall_cnt), .fetch_ack(fetch_ack),
   .byte_valid(byte_valid), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n)
);

// File: tb/pgmode_fetch_test.sv
module pgmode_fetch_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0;
   logic [1:0]  cfg_timing = 2'b00;
   logic        fetch_req = 1'b0;
   logic [15:0] fetch_addr = '0;
   logic [3:0]  stall_cnt = '0;
   logic        fetch_ack, byte_valid, bus_ale, bus_rd_n;
   logic [7:0]  byte_out, bus_addr, bus_data;
   logic [7:0]  hi_lat = '0;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit m_vld = 1'b0;
   logic [7:0] m_pg = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pgmode_fetch uut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_timing(cfg_timing),
      .fetch_req(fetch_req), .fetch_addr(fetch_addr), .stall_cnt(stall_cnt),
      .fetch_ack(fetch_ack), .byte_valid(byte_valid), .byte_out(byte_out),
      .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
      .bus_data(bus_data)
   );

   function automatic logic [7:0] memf(input logic [15:0] a);
      return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
   endfunction

   // external upper-byte latch plus asynchronous program memory
   always @(posedge clk) if (bus_ale) hi_lat <= bus_addr;
   assign bus_data = memf({hi_lat, bus_addr});

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic fetch(input logic [15:0] a, input int n);
      bit miss;
      miss = !m_vld || (a[15:8] != m_pg);
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = a; stall_cnt = 4'(n);
      #1;
      if (miss) begin
         check("R5 ale miss1", bus_ale, 1);
         check("R5 addr hi", bus_addr, a[15:8]);
         check("R5 no ack miss1", fetch_ack, 0);
         check("R7 rd low", bus_rd_n, 0);
         @(negedge clk); #1;
         check("R5 ale miss2", bus_ale, 0);
      end else begin
         check("R6 ale hit", bus_ale, 0);
      end
      check(miss ? "R5 addr lo" : "R6 addr lo", bus_addr, a[7:0]);
      check(miss ? "R10 ack miss" : "R6 ack hit", fetch_ack, 1);
      check("R7 rd low ack", bus_rd_n, 0);
      m_vld = 1'b1; m_pg = a[15:8];
      if (n == 0) begin
         @(negedge clk); fetch_req = 1'b0; #1;
         check("R8 valid", byte_valid, 1);
         check("R8 byte", byte_out, memf(a));
      end else begin
         for (int i = 0; i < n; i++) begin
            @(negedge clk); fetch_addr = 16'($urandom); #1;
            check("R9 stall no ack", fetch_ack, 0);
            check("R9 stall no ale", bus_ale, 0);
            check("R7 rd low stall", bus_rd_n, 0);
            if (i == 0) begin
               check("R8 valid", byte_valid, 1);
               check("R8 byte", byte_out, memf(a));
            end else begin
               check("R8 no stray valid", byte_valid, 0);
            end
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] pages [3];
      pages[0] = 8'h12; pages[1] = 8'h34; pages[2] = 8'hA0;
      void'($urandom(32'd4021));
      repeat (3) @(negedge clk);
      #1;
      check("R1 rd_n", bus_rd_n, 1);
      check("R1 ale", bus_ale, 0);
      check("R1 ack", fetch_ack, 0);
      check("R1 valid", byte_valid, 0);
      @(negedge clk); rst_n = 1'b1;

      // R2: enable with non-zero timing does not arm the mode
      @(negedge clk); cfg_timing = 2'b01; cfg_en = 1'b1;
      fetch_req = 1'b1; fetch_addr = 16'h1234;
      @(negedge clk); #1;
      check("R2 wrong order rd_n", bus_rd_n, 1);
      cfg_timing = 2'b00;
      repeat (2) @(negedge clk);
      #1;
      check("R2 late zero rd_n", bus_rd_n, 1);
      check("R3 off no ack", fetch_ack, 0);
      check("R3 off no ale", bus_ale, 0);
      fetch_req = 1'b0; cfg_en = 1'b0;
      @(negedge clk); cfg_en = 1'b1;
      @(negedge clk); #1;
      check("R2 armed rd_n", bus_rd_n, 0);

      // R4 first fetch misses; R6 hit; R9 multiply-like and adjust-like stalls
      fetch(16'h12C3, 0);
      fetch(16'h1213, 0);
      fetch(16'h12A4, 8);
      fetch(16'h12D4, 1);
      fetch(16'h1200, 0);
      fetch(16'h3445, 0);   // R10 branch to new page
      fetch(16'h3490, 0);

      // R3 mode off, then R4 re-entry misses on the same page
      @(negedge clk); cfg_en = 1'b0;
      @(negedge clk); fetch_req = 1'b1; fetch_addr = 16'h34A8; #1;
      check("R3 off rd_n", bus_rd_n, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk); #1;
         check("R3 off ale", bus_ale, 0);
         check("R3 off ack", fetch_ack, 0);
      end
      fetch_req = 1'b0; m_vld = 1'b0;
      cfg_en = 1'b1;
      @(negedge clk); #1;
      check("R2 rearm rd_n", bus_rd_n, 0);
      fetch(16'h34A8, 0);   // R4 must miss

      // timing field change drops the mode
      @(negedge clk); cfg_timing = 2'b10;
      @(negedge clk); #1;
      check("R2 field change rd_n", bus_rd_n, 1);
      cfg_timing = 2'b00; cfg_en = 1'b0;
      @(negedge clk); cfg_en = 1'b1; m_vld = 1'b0;
      @(negedge clk);

      for (int k = 0; k < 150; k++) begin
         int r;
         logic [15:0] a;
         int n;
         a = {pages[$urandom % 3], 8'($urandom)};
         r = int'($urandom % 6);
         n = (r < 3) ? 0 : ((r == 5) ? 8 : r - 2);
         fetch(a, n);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule